// File: doc/BRIEF.md
# Receiver Acquisition Mode Sequencer

This block steers the receive path of a narrowband data modem while it locks onto an incoming carrier. Host control bits and a bit-period tick are its only inputs. It drives a two-bit bandwidth select for the bit-synchronisation loop, a mode select for the level detector, a loop freeze output and a receiver enable. The loop filter, the level detectors and the demodulator are outside the block and only consume these selects.

While the host holds the acquire bit high, the loop runs wide and the level detector uses fast peak detection. When the acquire bit drops, the detector changes to averaging, and the loop runs at medium bandwidth for a programmable number of counted bit ticks before it settles at narrow bandwidth. An acquire pulse shorter than the programmed minimum produces a one-cycle violation flag. The hold bit freezes the loop during fades, but the block ignores it while acquiring. The power-save bit drops the whole sequencer to its off state.

Top module: `acq_mode_seq`

## Requirements
- R1: During and right after reset the outputs are: bandwidth select 00 (off), level detector in fast peak (0), receiver enable 0, loop hold 0, violation flag 0. The bandwidth encoding is 00 off, 01 wide, 10 medium, 11 narrow.
- R2: A cycle in which the power-save input is 1 puts the sequencer in the off state (select 00, enable 0) at the next clock edge and clears both bit-tick counts.
- R3: On the first edge with power-save at 0, the sequencer enters wide (01) if the acquire input is 1, and narrow (11) otherwise.
- R4: With power-save at 0, an acquire input of 1 selects wide (01) with fast peak detection (0) at the next edge, from any state, and restarts the sequence when it happens during medium or narrow.
- R5: When the acquire input is 0 in the wide state, the next edge selects medium (10) and switches the level detector to averaging (1), which stays on in medium and narrow.
- R6: In medium, a tick counts when the bit tick is 1 and both the hold and acquire inputs are 0. Once MED_TICKS ticks have been counted, the next edge selects narrow (11). Narrow is entered only from medium or from off.
- R7: The loop hold output equals the hold input AND NOT acquire AND NOT power-save, sampled one clock earlier.
- R8: While the acquire input is 1 the hold input has no effect: loop hold stays 0, and ticks still count toward the minimum acquire length.
- R9: While the hold input is 1 in medium, bit ticks do not advance the medium count, so the move to narrow is delayed by the held ticks.
- R10: A wide tick counts when the bit tick and the acquire input are both 1. If the acquire input drops after fewer than MIN_ACQ_TICKS such ticks, the violation flag is 1 for exactly the one cycle in which the select first shows medium. It stays 0 when at least MIN_ACQ_TICKS ticks were counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick_i | input | 1 | One-cycle pulse per received bit period |
| acq_i | input | 1 | Host acquire bit |
| hold_i | input | 1 | Host loop hold bit |
| rx_psave_i | input | 1 | Host receiver power-save bit |
| bw_sel_o | output | 2 | Loop bandwidth select (00 off, 01 wide, 10 medium, 11 narrow) |
| avg_detect_o | output | 1 | Level detector mode: 0 fast peak, 1 averaging |
| loop_hold_o | output | 1 | Freeze the bit-synchronisation loop |
| rx_enable_o | output | 1 | Receiver enabled |
| acq_short_o | output | 1 | One-cycle flag for an acquire pulse that was too short |

## Verification
Two events can fall in the same cycle. An acquire fall can coincide with the tick that would have completed the minimum count. A rising acquire can coincide with the tick that ends the medium period. The bench sweeps the length of the acquire pulse over a range of cycle counts, so the fall lands on each phase of the tick just below, at and above the minimum. It also raises acquire, together with hold, while medium is running. A behavioural reference model scores every output on every clock: a tick in the falling cycle must not count, and the acquire input must win over the move to narrow.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;

    typedef enum logic [1:0] {
        ST_OFF    = 2'b00,
        ST_WIDE   = 2'b01,
        ST_MED    = 2'b10,
        ST_NARROW = 2'b11
    } bw_state_e;

    typedef struct packed {
        bw_state_e state;
        logic      short_flag;
        logic      hold_flag;
    } seq_regs_t;

endpackage

// File: rtl/acq_tick_counter.sv
module acq_tick_counter #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic full_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] TOP = CW'(LIMIT);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (inc_i && (cnt_q != TOP)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign full_o = (cnt_q == TOP);

endmodule

// File: rtl/acq_mode_seq.sv
module acq_mode_seq
    import acq_seq_pkg::*;
#(
    parameter int MIN_ACQ_TICKS = 16,
    parameter int MED_TICKS     = 30
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_tick_i,
    input  logic       acq_i,
    input  logic       hold_i,
    input  logic       rx_psave_i,
    output logic [1:0] bw_sel_o,
    output logic       avg_detect_o,
    output logic       loop_hold_o,
    output logic       rx_enable_o,
    output logic       acq_short_o
);

    seq_regs_t r_d, r_q;

    logic acq_inc, acq_clr, acq_full;
    logic med_inc, med_clr, med_full;

    // Wide-phase tick count: only ticks seen with acquire still high count.
    assign acq_clr = (r_q.state != ST_WIDE);
    assign acq_inc = (r_q.state == ST_WIDE) && acq_i && bit_tick_i && !rx_psave_i;

    // Medium-phase tick count: paused by hold, abandoned by acquire.
    assign med_clr = (r_q.state != ST_MED);
    assign med_inc = (r_q.state == ST_MED) && bit_tick_i && !hold_i
                     && !acq_i && !rx_psave_i;

    acq_tick_counter #(.LIMIT(MIN_ACQ_TICKS)) u_acq_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (acq_clr),
        .inc_i  (acq_inc),
        .full_o (acq_full)
    );

    acq_tick_counter #(.LIMIT(MED_TICKS)) u_med_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (med_clr),
        .inc_i  (med_inc),
        .full_o (med_full)
    );

    always_comb begin
        r_d            = r_q;
        r_d.short_flag = 1'b0;
        r_d.hold_flag  = hold_i && !acq_i && !rx_psave_i;
        if (rx_psave_i) begin
            r_d.state = ST_OFF;
        end else begin
            unique case (r_q.state)
                ST_OFF: begin
                    r_d.state = acq_i ? ST_WIDE : ST_NARROW;
                end
                ST_WIDE: begin
                    if (!acq_i) begin
                        r_d.state      = ST_MED;
                        r_d.short_flag = !acq_full;
                    end
                end
                ST_MED: begin
                    if (acq_i) begin
                        r_d.state = ST_WIDE;
                    end else if (med_full) begin
                        r_d.state = ST_NARROW;
                    end
                end
                ST_NARROW: begin
                    if (acq_i) begin
                        r_d.state = ST_WIDE;
                    end
                end
                default: r_d.state = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_OFF, short_flag: 1'b0, hold_flag: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign bw_sel_o     = r_q.state;
    assign avg_detect_o = (r_q.state == ST_MED) || (r_q.state == ST_NARROW);
    assign rx_enable_o  = (r_q.state != ST_OFF);
    assign loop_hold_o  = r_q.hold_flag;
    assign acq_short_o  = r_q.short_flag;

endmodule

// File: rtl/acq_mode_seq_chk.sv
module acq_mode_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       acq_i,
    input logic       hold_i,
    input logic       rx_psave_i,
    input logic [1:0] bw_sel_o,
    input logic       avg_detect_o,
    input logic       loop_hold_o,
    input logic       rx_enable_o,
    input logic       acq_short_o
);

    assert_psave_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_psave_i |=> (bw_sel_o == 2'b00 && !rx_enable_o));

    assert_acq_wide_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_i && !rx_psave_i) |=> (bw_sel_o == 2'b01 && !avg_detect_o));

    assert_hold_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && !acq_i && !rx_psave_i) |=> loop_hold_o);

    assert_hold_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        acq_i |=> !loop_hold_o);

    assert_narrow_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bw_sel_o == 2'b11 && $past(bw_sel_o) != 2'b11)
            |-> ($past(bw_sel_o) == 2'b10 || $past(bw_sel_o) == 2'b00));

    assert_short_in_med_R10: assert property (@(posedge clk) disable iff (!rst_n)
        acq_short_o |-> (bw_sel_o == 2'b10 && avg_detect_o));

endmodule

bind acq_mode_seq acq_mode_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .acq_i        (acq_i),
    .hold_i       (hold_i),
    .rx_psave_i   (rx_psave_i),
    .bw_sel_o     (bw_sel_o),
    .avg_detect_o (avg_detect_o),
    .loop_hold_o  (loop_hold_o),
    .rx_enable_o  (rx_enable_o),
    .acq_short_o  (acq_short_o)
);

// File: tb/acq_mode_seq_tb_top.sv
module acq_mode_seq_tb_top;

    localparam int MIN_T = 16;
    localparam int MED_T = 30;
    localparam int TICK_DIV = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_tick = 1'b0;
    logic acq = 1'b0;
    logic hold = 1'b0;
    logic psave = 1'b1;
    logic [1:0] bw_sel;
    logic avg_det, loop_hold, rx_en, acq_short;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    acq_mode_seq #(.MIN_ACQ_TICKS(MIN_T), .MED_TICKS(MED_T)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_tick_i   (bit_tick),
        .acq_i        (acq),
        .hold_i       (hold),
        .rx_psave_i   (psave),
        .bw_sel_o     (bw_sel),
        .avg_detect_o (avg_det),
        .loop_hold_o  (loop_hold),
        .rx_enable_o  (rx_en),
        .acq_short_o  (acq_short)
    );

    // Behavioural reference: mode 0 off, 1 wide, 2 medium, 3 narrow.
    int m_mode = 0;
    int m_acnt = 0;
    int m_mcnt = 0;
    bit m_short = 1'b0;
    bit m_hold = 1'b0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_acnt = 0; m_mcnt = 0; m_short = 0; m_hold = 0;
        end else begin
            int nmode, nacnt, nmcnt;
            bit nshort;
            nmode = m_mode; nshort = 0;
            nacnt = m_acnt; nmcnt = m_mcnt;
            if (m_mode == 1 && acq && bit_tick && !psave && nacnt < MIN_T) nacnt++;
            if (m_mode != 1) nacnt = 0;
            if (m_mode == 2 && bit_tick && !hold && !acq && !psave && nmcnt < MED_T) nmcnt++;
            if (m_mode != 2) nmcnt = 0;
            if (psave) nmode = 0;
            else if (m_mode == 0) nmode = acq ? 1 : 3;
            else if (acq) nmode = 1;
            else if (m_mode == 1) begin nmode = 2; nshort = (m_acnt < MIN_T); end
            else if (m_mode == 2 && m_mcnt == MED_T) nmode = 3;
            m_hold = hold && !acq && !psave;
            m_mode = nmode; m_acnt = nacnt; m_mcnt = nmcnt; m_short = nshort;
        end
    end

    task automatic check_bit(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    task automatic compare_all();
        check_bit("R2 R3 R4 R5 R6 R9 bw_sel", int'(bw_sel), m_mode);
        check_bit("R1 R4 R5 avg_detect", int'(avg_det), (m_mode >= 2) ? 1 : 0);
        check_bit("R1 R2 rx_enable", int'(rx_en), (m_mode != 0) ? 1 : 0);
        check_bit("R7 R8 loop_hold", int'(loop_hold), int'(m_hold));
        check_bit("R10 acq_short", int'(acq_short), int'(m_short));
    endtask

    task automatic run(input int n, input bit a, input bit h, input bit p);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare_all();
            cyc++;
            acq = a; hold = h; psave = p;
            bit_tick = ((cyc % TICK_DIV) == 0);
        end
    endtask

    initial begin
        // R1: reset state
        run(4, 0, 0, 1);
        rst_n = 1'b1;
        // R2: power-save held
        run(6, 0, 0, 1);
        // R3 R4: leave power-save acquiring, long acquire
        run(20 * TICK_DIV, 1, 0, 0);
        // R5 R6: medium then narrow
        run((MED_T + 6) * TICK_DIV, 0, 0, 0);
        // R7: hold in narrow
        run(20, 0, 1, 0);
        run(4, 0, 0, 0);
        // R10: short acquire
        run(5 * TICK_DIV, 1, 0, 0);
        run(10, 0, 0, 0);
        // R10: sweep around the minimum count
        for (int k = (MIN_T - 1) * TICK_DIV; k <= (MIN_T + 1) * TICK_DIV; k++) begin
            run(k, 1, 0, 0);
            run(6, 0, 0, 0);
        end
        // R9: hold pauses medium count; R8: acquire with hold
        run(40, 0, 1, 0);
        run(8, 1, 1, 0);
        run(40, 0, 0, 0);
        run(24, 0, 1, 0);
        run((MED_T + 4) * TICK_DIV, 0, 0, 0);
        // R4: restart during medium, at and near the end of medium
        run(70, 1, 0, 0);
        run(40, 0, 0, 0);
        run(10, 1, 0, 0);
        run(MED_T * TICK_DIV, 0, 0, 0);
        run(3, 1, 0, 0);
        run(20, 0, 0, 0);
        // R2 R3: power-save mid medium, leave with acquire low then high
        run(70, 1, 0, 0);
        run(20, 0, 1, 0);
        run(5, 0, 1, 1);
        run(10, 0, 0, 0);
        run(3, 1, 0, 1);
        run(10, 1, 0, 0);
        run(4, 0, 0, 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule